// File: doc/BRIEF.md
# Packed Saturating Integer Adder

This unit adds or subtracts two 64-bit operands treated as a group of independent integer lanes. A lane-size select splits the word into eight byte lanes, four halfword lanes or two word lanes. One operation then applies to every lane in the same cycle, and no carry or borrow crosses from one lane into the next. A fourth lane-size code turns the whole word into a single plain 64-bit adder.

An arithmetic-mode select sets what each lane does when its result leaves the lane's range:
- In wrap mode the lane keeps its low bits.
- In signed saturating mode the lane clamps to its most positive or most negative two's-complement value.
- In unsigned saturating mode the lane clamps to all ones on an add overflow and to zero on a subtract underflow.

Alongside the result, an eight-bit indicator marks every byte position that belongs to a clamped lane. The unit handles integers only. The result and indicator are registered and appear on the clock edge after the cycle in which the inputs were presented with the valid strobe.

Top module: `packed_sat_adder`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid`, `result` and `sat_flags` show that operation after that edge. When `in_valid` is low at an edge, `out_valid` goes low and `result` and `sat_flags` hold their values.
- R2: While `rst_n` is low, `out_valid`, `result` and `sat_flags` are all zero.
- R3: The `lane_sel` encoding is 2'b00 for eight 8-bit lanes, 2'b01 for four 16-bit lanes and 2'b10 for two 32-bit lanes. Lane k occupies bits [k*w+w-1 : k*w], and no carry or borrow passes between lanes.
- R4: `mode` 2'b00 and 2'b11 select wrap arithmetic. Each lane result is taken modulo 2^w, and `sat_flags` is all zero.
- R5: `mode` 2'b01 selects signed saturation. A lane whose exact signed result exceeds 2^(w-1)-1 gives 2^(w-1)-1. A lane whose result is below -2^(w-1) gives -2^(w-1).
- R6: `mode` 2'b10 selects unsigned saturation. An add above 2^w-1 gives all ones, and a subtract below zero gives zero.
- R7: `op_sub` = 0 computes A+B in every lane, and `op_sub` = 1 computes A-B.
- R8: Bit i of `sat_flags` is set exactly when byte i (bits [8i+7:8i]) lies in a lane that was clamped.
- R9: `lane_sel` 2'b11 computes the 64-bit sum A+B modulo 2^64, ignoring `op_sub` and `mode`, with `sat_flags` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract B from A |
| lane_sel | input | 2 | Lane size: 00 byte, 01 halfword, 10 word, 11 full 64-bit add |
| mode | input | 2 | 00/11 wrap, 01 signed saturate, 10 unsigned saturate |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Registered result is from a valid operation |
| result | output | 64 | Registered packed result |
| sat_flags | output | 8 | Registered per-byte clamp indicator |

## Verification
The assertions assume that `in_valid` is low during reset and that every control input has a defined value at each sampled edge. Under those conditions, any combination of `op_sub`, `lane_sel` and `mode` is a legal operation whose next-cycle output can be predicted. The stimulus drives all inputs between clock edges and holds `in_valid` low through reset. After that it presents every lane size and mode, both directions of overflow, and idle cycles mixed at random with valid ones. This keeps the checks on flag grouping, hold behaviour and the full-width adder within their assumptions.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic [1:0] {
    LANE_B8   = 2'b00,
    LANE_B16  = 2'b01,
    LANE_B32  = 2'b10,
    LANE_FULL = 2'b11
  } lane_e;

  typedef enum logic [1:0] {
    MODE_WRAP  = 2'b00,
    MODE_SSAT  = 2'b01,
    MODE_USAT  = 2'b10,
    MODE_WRAP2 = 2'b11
  } arith_e;
endpackage

// File: rtl/psa_byte_add.sv
module psa_byte_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         a_top,
  output logic         b_top
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff       = b ^ {W{sub}};
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    a_top       = a[W-1];
    b_top       = b_eff[W-1];
  end
endmodule

// File: rtl/psa_lane_chain.sv
module psa_lane_chain
  import psa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub_eff,
  input  lane_e             lane_code,
  output logic [DATA_W-1:0] sum,
  output logic [NSEG-1:0]   cout,
  output logic [NSEG-1:0]   a_top,
  output logic [NSEG-1:0]   b_top
);
  logic [NSEG-1:0] seg_start;
  logic [NSEG-1:0] cin;

  // A segment starts a new lane when its index is aligned to the lane size.
  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      if (lane_code == LANE_FULL) begin
        seg_start[i] = (i == 0);
      end else begin
        seg_start[i] = ((i & ((1 << int'(lane_code)) - 1)) == 0);
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_seg
      if (g == 0) begin : g_first
        assign cin[g] = sub_eff;
      end else begin : g_rest
        assign cin[g] = seg_start[g] ? sub_eff : cout[g-1];
      end

      psa_byte_add #(.W(SEG_W)) u_add (
        .a     (opa[g*SEG_W +: SEG_W]),
        .b     (opb[g*SEG_W +: SEG_W]),
        .sub   (sub_eff),
        .cin   (cin[g]),
        .sum   (sum[g*SEG_W +: SEG_W]),
        .cout  (cout[g]),
        .a_top (a_top[g]),
        .b_top (b_top[g])
      );
    end
  endgenerate
endmodule

// File: rtl/psa_clamp.sv
module psa_clamp
  import psa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] sum,
  input  logic [NSEG-1:0]   cout,
  input  logic [NSEG-1:0]   a_top,
  input  logic [NSEG-1:0]   b_top,
  input  logic              sub_eff,
  input  lane_e             lane_code,
  input  arith_e            arith,
  output logic [DATA_W-1:0] res,
  output logic [NSEG-1:0]   clamped
);
  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      int  top;
      logic s_top, s_ovf, u_ovf, neg, hit;
      logic [SEG_W-1:0] fill;

      // The top segment of the lane holds the sign and the lane carry.
      if (lane_code == LANE_FULL) top = NSEG - 1;
      else                        top = i | ((1 << int'(lane_code)) - 1);

      s_top = sum[top*SEG_W + SEG_W - 1];
      s_ovf = (a_top[top] == b_top[top]) && (s_top != a_top[top]);
      u_ovf = sub_eff ? ~cout[top] : cout[top];
      neg   = a_top[top];

      hit = 1'b0;
      if (lane_code != LANE_FULL) begin
        if (arith == MODE_SSAT) hit = s_ovf;
        if (arith == MODE_USAT) hit = u_ovf;
      end

      if (arith == MODE_SSAT) begin
        if (i == top) fill = neg ? {1'b1, {(SEG_W-1){1'b0}}} : {1'b0, {(SEG_W-1){1'b1}}};
        else          fill = neg ? {SEG_W{1'b0}} : {SEG_W{1'b1}};
      end else begin
        fill = sub_eff ? {SEG_W{1'b0}} : {SEG_W{1'b1}};
      end

      clamped[i]             = hit;
      res[i*SEG_W +: SEG_W]  = hit ? fill : sum[i*SEG_W +: SEG_W];
    end
  end
endmodule

// File: rtl/packed_sat_adder.sv
module packed_sat_adder
  import psa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [NSEG-1:0]   sat_flags
);
  lane_e             lane_code;
  arith_e            arith;
  logic              sub_eff;
  logic [DATA_W-1:0] raw_sum;
  logic [NSEG-1:0]   seg_cout, seg_a_top, seg_b_top;
  logic [DATA_W-1:0] lane_res;
  logic [NSEG-1:0]   lane_clamp;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] res_d, res_q;
  logic [NSEG-1:0]   flag_d, flag_q;

  always_comb begin
    lane_code = lane_e'(lane_sel);
    arith     = arith_e'(mode);
    sub_eff   = op_sub && (lane_code != LANE_FULL);
  end

  psa_lane_chain #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chain (
    .opa       (opa),
    .opb       (opb),
    .sub_eff   (sub_eff),
    .lane_code (lane_code),
    .sum       (raw_sum),
    .cout      (seg_cout),
    .a_top     (seg_a_top),
    .b_top     (seg_b_top)
  );

  psa_clamp #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_clamp (
    .sum       (raw_sum),
    .cout      (seg_cout),
    .a_top     (seg_a_top),
    .b_top     (seg_b_top),
    .sub_eff   (sub_eff),
    .lane_code (lane_code),
    .arith     (arith),
    .res       (lane_res),
    .clamped   (lane_clamp)
  );

  // Next-state: load on a valid operation, hold otherwise.
  always_comb begin
    valid_d = in_valid;
    res_d   = in_valid ? lane_res   : res_q;
    flag_d  = in_valid ? lane_clamp : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flag_q  <= '0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      flag_q  <= flag_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign sat_flags = flag_q;
endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              op_sub,
  input logic [1:0]        lane_sel,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [NSEG-1:0]   sat_flags
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(sat_flags)));

  a_r4_wrap_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode[0] == mode[1])) |=> (sat_flags == '0));

  a_r9_full_add: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (lane_sel == 2'b11)) |=>
      ((result == $past(opa) + $past(opb)) && (sat_flags == '0)));

  a_r8_half_groups: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (lane_sel == 2'b01)) |=>
      ((sat_flags[0] == sat_flags[1]) && (sat_flags[2] == sat_flags[3]) &&
       (sat_flags[4] == sat_flags[5]) && (sat_flags[6] == sat_flags[7])));

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_byte
      a_r6_uns_add_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == 2'b10) && !op_sub && (lane_sel == 2'b00)) |=>
          (!sat_flags[g] || (result[g*SEG_W +: SEG_W] == {SEG_W{1'b1}})));
    end
  endgenerate
endmodule

bind packed_sat_adder psa_checker #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_psa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sub    (op_sub),
  .lane_sel  (lane_sel),
  .mode      (mode),
  .opa       (opa),
  .opb       (opb),
  .out_valid (out_valid),
  .result    (result),
  .sat_flags (sat_flags)
);

// File: tb/packed_sat_adder_bench.sv
`timescale 1ns/1ps
module packed_sat_adder_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        op_sub;
  logic [1:0]  lane_sel;
  logic [1:0]  mode;
  logic [63:0] opa, opb;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  sat_flags;

  int checks = 0;
  int failures = 0;
  logic        exp_valid;
  logic [63:0] exp_res;
  logic [7:0]  exp_flags;

  packed_sat_adder u_packed_sat_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .lane_sel(lane_sel), .mode(mode), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference: exact lane arithmetic in wide integers.
  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic sub,
                       input logic [1:0] ls, input logic [1:0] md,
                       output logic [63:0] r, output logic [7:0] f);
    int w, n, bpl;
    longint mask, ua, ub, sa, sb, us, ss, v, smax, smin;
    logic clip;
    r = '0;
    f = '0;
    if (ls == 2'b11) begin
      r = a + b;
      return;
    end
    w    = 8 << ls;
    n    = 64 / w;
    bpl  = w / 8;
    mask = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    for (int k = 0; k < n; k++) begin
      ua = longint'(a >> (k * w)) & mask;
      ub = longint'(b >> (k * w)) & mask;
      sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
      sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
      us = sub ? ua - ub : ua + ub;
      ss = sub ? sa - sb : sa + sb;
      v = us;
      clip = 1'b0;
      if (md == 2'b01) begin
        if (ss > smax) begin v = smax; clip = 1'b1; end
        else if (ss < smin) begin v = smin; clip = 1'b1; end
        else v = ss;
      end else if (md == 2'b10) begin
        if (us > mask) begin v = mask; clip = 1'b1; end
        else if (us < 0) begin v = 0; clip = 1'b1; end
      end
      r = r | ((64'(v) & 64'(mask)) << (k * w));
      if (clip) for (int j = 0; j < bpl; j++) f[k*bpl + j] = 1'b1;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (out_valid !== exp_valid || result !== exp_res || sat_flags !== exp_flags) begin
      failures++;
      $display("FAIL %s: actual v=%b r=%h f=%h expected v=%b r=%h f=%h",
               tag, out_valid, result, sat_flags, exp_valid, exp_res, exp_flags);
    end
  endtask

  // Drive at the falling edge, check shortly after the next rising edge.
  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic sub, input logic [1:0] ls, input logic [1:0] md,
                      input string tag);
    logic [63:0] r;
    logic [7:0]  f;
    in_valid = v; opa = a; opb = b; op_sub = sub; lane_sel = ls; mode = md;
    model(a, b, sub, ls, md, r, f);
    exp_valid = v;
    if (v) begin exp_res = r; exp_flags = f; end
    @(posedge clk);
    #2;
    check(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; lane_sel = 2'b00; mode = 2'b00;
    opa = '0; opb = '0;
    exp_valid = 1'b0; exp_res = '0; exp_flags = '0;
    repeat (3) @(negedge clk);
    check("R2 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: byte lanes wrap without carrying into a neighbour
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 2'b00, 2'b00, "R3 byte wrap");
    // R3: carry stays inside a halfword, not past it
    step(1, 64'h00FF_FFFF_00FF_FFFF, 64'h0001_0001_0001_0001, 0, 2'b01, 2'b00, "R3 half carry");
    step(1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 0, 2'b10, 2'b11, "R4 word wrap alt");
    // R7: subtract with borrow confined to the lane
    step(1, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 1, 2'b10, 2'b00, "R7 word sub");
    // R5 R8: signed clamps both ways, byte lanes
    step(1, 64'h7F80_7F80_1020_F0E0, 64'h0101_8001_1010_F0F0, 0, 2'b00, 2'b01, "R5 byte signed add");
    step(1, 64'h807F_0000_7FFF_8000, 64'h0180_0001_FFFF_0001, 1, 2'b00, 2'b01, "R5 byte signed sub");
    step(1, 64'h7FFF_8000_1234_0001, 64'h0001_FFFF_1111_0001, 0, 2'b01, 2'b01, "R8 half signed");
    step(1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 0, 2'b10, 2'b01, "R5 word signed");
    // R6: unsigned clamps
    step(1, 64'hFFFF_0001_FF00_8000, 64'h0001_0001_0100_8000, 0, 2'b01, 2'b10, "R6 half uns add");
    step(1, 64'h0000_0005_0001_FFFF, 64'h0001_0003_0002_FFFF, 1, 2'b01, 2'b10, "R6 half uns sub");
    step(1, 64'hF0FF_01FE_8000_0101, 64'h2001_FF01_8001_FF00, 0, 2'b00, 2'b10, "R6 byte uns add");
    // R9: full-width add ignores op_sub and mode
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, 1, 2'b11, 2'b01, "R9 full add");
    step(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 0, 2'b11, 2'b10, "R9 full carry out");
    // R1: idle cycles hold the last result
    step(0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 1, 2'b00, 2'b01, "R1 idle hold");
    step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2'b00, 2'b10, "R1 idle hold 2");

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom},
           1'($urandom), 2'($urandom), 2'($urandom), "R1 R4 R5 R6 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule